// File: doc/BRIEF.md
# Two-Threshold Link Error Monitor

This block watches a high-speed serial receiver for reported bit or code errors and keeps a running count of them. Management software programs two limits on that count. Passing the lower limit flags a degrading line as an early warning while the link stays in use. Passing the upper limit flags the line as unusable and drops the link-in-service output. Every reported error also produces a one-cycle request for the receiver to resynchronise.

The count can be taken over a programmable window of clock cycles, after which it restarts from zero. Alert status survives the restart. A window length of zero turns the restart off, so the count accumulates. The count stops at its largest value and does not wrap. Alert status bits are sticky and are cleared by writing one. Each has an enable that gates it onto the interrupt output. Once taken down, the link stays down until software asks to restore it.

Error detection itself, such as line-code decoding, happens upstream and arrives as a single-cycle event input.

Top module: `ber_monitor`

## Requirements
- R1: After reset the count is 0, both status bits are 0, link_up is 1, irq and resync_req are 0, both limits are all ones and the window length is 0.
- R2: Each cycle with err_evt high adds one to the count, which can be read at address 5 from the cycle after the event.
- R3: The count stops at its maximum value (all ones) and never wraps.
- R4: resync_req is high for exactly the cycle after each cycle in which err_evt is high, and low otherwise.
- R5: When the count exceeds the warning limit (address 2), status bit 0 (address 1) is set one cycle later, and link_up stays 1.
- R6: When the count exceeds the take-down limit (address 3), status bit 1 is set and link_up drops to 0 one cycle later.
- R7: While the count is at or below both limits, no status bit is set and link_up stays 1.
- R8: If the warning limit is at or above the take-down limit, crossing the take-down limit sets both status bits.
- R9: Status bits stay set until a one is written to them at address 1. A zero written there has no effect. A new crossing in the same cycle as a clear keeps the bit set.
- R10: irq is high when status bit 0 is set with control bit 0 (address 0) set, or when status bit 1 is set with control bit 1 set.
- R11: After a take-down, link_up stays 0 until a one is written to control bit 2. If the count is still above the take-down limit at that moment, the link stays down.
- R12: With a nonzero window length W (address 4), the count returns to zero W cycles after the window register is written, and after each later W cycles. Status bits are kept. With W = 0 the count is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | 1 | One error event from the receiver per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr, combinational |
| resync_req | output | 1 | Resynchronisation request pulse |
| link_up | output | 1 | Link in service |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
Error bursts are sized to land exactly on a limit and one past it. This separates a strict "exceeds" comparison from "reaches". A long burst past the counter's top value shows saturation as distinct from wraparound. Limit pairs are also programmed in inverted order, to show that the warning still fires together with the take-down. Clears and restore requests are issued both while the count is still above a limit and after it has fallen. This shows whether new crossings take priority over software action. A window run confirms that the count resets while the alerts it caused remain.

// File: rtl/ber_pkg.sv
package ber_pkg;
  // register addresses
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_WARN = 3'd2;
  localparam logic [2:0] ADDR_DOWN = 3'd3;
  localparam logic [2:0] ADDR_WIN  = 3'd4;
  localparam logic [2:0] ADDR_CNT  = 3'd5;
  // control bits
  localparam int CTL_WARN_EN = 0;
  localparam int CTL_DOWN_EN = 1;
  localparam int CTL_RESTORE = 2;
  // status bits
  localparam int ST_WARN = 0;
  localparam int ST_DOWN = 1;
  localparam int ST_LINK = 2;
endpackage

// File: rtl/ber_window_counter.sv
module ber_window_counter #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic [WIN_W-1:0] win_len,
  input  logic             win_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             win_end
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [WIN_W-1:0] timer;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  assign win_end = (win_len != '0) && (timer == win_len - 1'b1) && !win_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (win_wr || win_end || win_len == '0) begin
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (win_end) begin
      cnt <= err_evt ? CNT_W'(1) : '0;
    end else if (err_evt) begin
      cnt <= sat_inc(cnt);
    end
  end

  // R3: a full counter stays full unless a window ends
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !win_end) |=> cnt == CMAX);
  // R12: a window end leaves at most the one new event
  a_r12_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> cnt <= CNT_W'(1));
  // R2: without an event and window end the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_evt && !win_end) |=> $stable(cnt));
endmodule

// File: rtl/ber_severity.sv
module ber_severity #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] warn_lim,
  input  logic [CNT_W-1:0] down_lim,
  input  logic             clr_warn,
  input  logic             clr_down,
  input  logic             restore,
  output logic             warn_hit,
  output logic             down_hit,
  output logic             warn_sts,
  output logic             down_sts,
  output logic             link_up
);
  function automatic logic exceeds(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] lim);
    return v > lim;
  endfunction

  assign down_hit = exceeds(cnt, down_lim);
  // an inverted pair still warns on take-down
  assign warn_hit = exceeds(cnt, warn_lim) || down_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_sts <= 1'b0;
      down_sts <= 1'b0;
      link_up  <= 1'b1;
    end else begin
      warn_sts <= (warn_sts && !clr_warn) || warn_hit;
      down_sts <= (down_sts && !clr_down) || down_hit;
      if (down_hit)     link_up <= 1'b0;
      else if (restore) link_up <= 1'b1;
    end
  end

  // R9: sticky unless cleared
  a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_sts && !clr_warn) |=> warn_sts);
  a_r9_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (down_sts && !clr_down) |=> down_sts);
  // R11: a downed link needs a restore request
  a_r11_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !restore) |=> !link_up);
  // R8: take-down status never appears without the warning
  a_r8_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_sts) |-> warn_sts);
endmodule

// File: rtl/ber_regs.sv
module ber_regs
  import ber_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              warn_sts,
  input  logic              down_sts,
  input  logic              link_up,
  input  logic [CNT_W-1:0]  cnt,
  output logic              warn_en,
  output logic              down_en,
  output logic [CNT_W-1:0]  warn_lim,
  output logic [CNT_W-1:0]  down_lim,
  output logic [WIN_W-1:0]  win_len,
  output logic              win_wr,
  output logic              clr_warn,
  output logic              clr_down,
  output logic              restore,
  output logic [DATA_W-1:0] reg_rdata
);
  logic wr_ctrl, wr_stat;

  assign wr_ctrl  = reg_we && reg_addr == ADDR_CTRL;
  assign wr_stat  = reg_we && reg_addr == ADDR_STAT;
  assign win_wr   = reg_we && reg_addr == ADDR_WIN;
  assign clr_warn = wr_stat && reg_wdata[ST_WARN];
  assign clr_down = wr_stat && reg_wdata[ST_DOWN];
  assign restore  = wr_ctrl && reg_wdata[CTL_RESTORE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn_en  <= 1'b0;
      down_en  <= 1'b0;
      warn_lim <= '1;
      down_lim <= '1;
      win_len  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_CTRL: begin
          warn_en <= reg_wdata[CTL_WARN_EN];
          down_en <= reg_wdata[CTL_DOWN_EN];
        end
        ADDR_WARN: warn_lim <= reg_wdata[CNT_W-1:0];
        ADDR_DOWN: down_lim <= reg_wdata[CNT_W-1:0];
        ADDR_WIN:  win_len  <= reg_wdata[WIN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTL_WARN_EN] = warn_en;
        reg_rdata[CTL_DOWN_EN] = down_en;
      end
      ADDR_STAT: begin
        reg_rdata[ST_WARN] = warn_sts;
        reg_rdata[ST_DOWN] = down_sts;
        reg_rdata[ST_LINK] = link_up;
      end
      ADDR_WARN: reg_rdata = DATA_W'(warn_lim);
      ADDR_DOWN: reg_rdata = DATA_W'(down_lim);
      ADDR_WIN:  reg_rdata = DATA_W'(win_len);
      ADDR_CNT:  reg_rdata = DATA_W'(cnt);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ber_monitor.sv
module ber_monitor #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              resync_req,
  output logic              link_up,
  output logic              irq
);
  logic             warn_en, down_en, win_wr, clr_warn, clr_down, restore;
  logic [CNT_W-1:0] warn_lim, down_lim, cnt;
  logic [WIN_W-1:0] win_len;
  logic             win_end, warn_hit, down_hit, warn_sts, down_sts;

  ber_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .warn_sts(warn_sts), .down_sts(down_sts),
    .link_up(link_up), .cnt(cnt), .warn_en(warn_en), .down_en(down_en),
    .warn_lim(warn_lim), .down_lim(down_lim), .win_len(win_len),
    .win_wr(win_wr), .clr_warn(clr_warn), .clr_down(clr_down),
    .restore(restore), .reg_rdata(reg_rdata));

  ber_window_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .win_len(win_len),
    .win_wr(win_wr), .cnt(cnt), .win_end(win_end));

  ber_severity #(.CNT_W(CNT_W)) u_sev (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .warn_lim(warn_lim),
    .down_lim(down_lim), .clr_warn(clr_warn), .clr_down(clr_down),
    .restore(restore), .warn_hit(warn_hit), .down_hit(down_hit),
    .warn_sts(warn_sts), .down_sts(down_sts), .link_up(link_up));

  always_ff @(posedge clk) begin
    if (!rst_n) resync_req <= 1'b0;
    else        resync_req <= err_evt;
  end

  assign irq = (warn_sts && warn_en) || (down_sts && down_en);

  // R4: one request per event, in the following cycle
  a_r4_resync: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> resync_req);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !err_evt |=> !resync_req);
  // R6: a count over the take-down limit drops the link
  a_r6_takedown: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > down_lim) |=> (!link_up && down_sts));
  // R5: a count over the warning limit flags the warning
  a_r5_warn: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > warn_lim) |=> warn_sts);
endmodule

// File: tb/ber_monitor_test.sv
module ber_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          err_evt = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          resync_req, link_up, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ber_monitor #(.DATA_W(DW), .CNT_W(CW), .WIN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .resync_req(resync_req), .link_up(link_up), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      err_evt = 1'b1;
    end
    @(negedge clk);
    err_evt = 1'b0;
  endtask

  task automatic clear_count();
    wr(3'd4, 1);
    wr(3'd4, 0);
  endtask

  task automatic t_reset();
    int v;
    rd(3'd5, v); check("R1 count", v, 0);
    rd(3'd1, v); check("R1 status", v, 4);
    rd(3'd2, v); check("R1 warn limit", v, 255);
    rd(3'd3, v); check("R1 down limit", v, 255);
    rd(3'd4, v); check("R1 window", v, 0);
    check("R1 irq", int'(irq), 0);
    check("R1 resync", int'(resync_req), 0);
  endtask

  task automatic t_count_resync();
    int v;
    @(negedge clk); err_evt = 1'b1;
    @(negedge clk); check("R4 resync after event", int'(resync_req), 1);
    err_evt = 1'b0;
    @(negedge clk); check("R4 resync one cycle", int'(resync_req), 0);
    err_evt = 1'b1;
    @(negedge clk); @(negedge clk);
    err_evt = 1'b0;
    rd(3'd5, v); check("R2 count three", v, 3);
    @(negedge clk);
    check("R4 resync low", int'(resync_req), 0);
  endtask

  task automatic t_saturate();
    int v;
    burst(300);
    @(negedge clk);
    rd(3'd5, v); check("R3 saturated", v, 255);
    rd(3'd1, v); check("R7 at limit no alert", v, 4);
    check("R7 link up", int'(link_up), 1);
    clear_count();
    rd(3'd5, v); check("R12 window one clears", v, 0);
  endtask

  task automatic t_warn();
    int v;
    wr(3'd2, 4); wr(3'd3, 200); wr(3'd0, 1);
    burst(4); @(negedge clk);
    rd(3'd1, v); check("R7 count equals warn limit", v, 4);
    burst(1); @(negedge clk);
    rd(3'd1, v); check("R5 warn set", v, 5);
    check("R10 irq warn enabled", int'(irq), 1);
    wr(3'd1, 0);
    rd(3'd1, v); check("R9 write zero ignored", v, 5);
    wr(3'd1, 1);
    rd(3'd1, v); check("R9 set beats clear", v, 5);
    wr(3'd0, 0);
    check("R10 irq masked", int'(irq), 0);
    clear_count();
    wr(3'd1, 1);
    rd(3'd1, v); check("R9 cleared", v, 4);
  endtask

  task automatic t_down();
    int v;
    wr(3'd2, 200); wr(3'd3, 6); wr(3'd0, 2);
    burst(7); @(negedge clk);
    rd(3'd1, v); check("R6/R8 both set", v, 3);
    check("R6 link down", int'(link_up), 0);
    check("R10 irq down", int'(irq), 1);
    clear_count();
    wr(3'd1, 3);
    @(negedge clk);
    check("R11 still down", int'(link_up), 0);
    wr(3'd0, 4);
    check("R11 restored", int'(link_up), 1);
  endtask

  task automatic t_inverted();
    int v;
    wr(3'd2, 10); wr(3'd3, 3);
    burst(4); @(negedge clk);
    rd(3'd1, v); check("R8 inverted pair both", v, 3);
    wr(3'd0, 4);
    check("R11 restore loses to takedown", int'(link_up), 0);
    clear_count();
    wr(3'd1, 3);
    wr(3'd0, 4);
  endtask

  task automatic t_window();
    int v;
    wr(3'd2, 2); wr(3'd3, 200);
    wr(3'd4, 20);
    burst(5);
    rd(3'd5, v); check("R12 count inside window", v, 5);
    repeat (20) @(negedge clk);
    rd(3'd5, v); check("R12 count cleared at window end", v, 0);
    rd(3'd1, v); check("R12 status kept", v, 5);
    wr(3'd4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_resync();
    clear_count();
    t_saturate();
    t_warn();
    t_down();
    t_inverted();
    t_window();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule